// File: doc/BRIEF.md
# Synchronous Burst Read Responder for Pseudo-Static RAM

This block is the memory side of a clocked burst read port on a pseudo-static RAM. The host lowers chip-select, pulses address-valid low and presents an address. The block takes the address on the first rising clock edge where both strobes are low. It counts a fixed initial latency and then returns a burst of words on consecutive clocks. A ready indication, active high and driven only while chip-select is low, tells the host when the data bus carries valid data. After the burst the last word stays on the bus until the host releases output-enable or chip-select.

The block reads from a small array of flip-flops. A preload port fills this array, so the same block can serve as a behavioural memory in a system simulation or as a synthesizable stand-in. Each byte lane of the data bus has its own drive enable. A lane is enabled only when output-enable and that lane's byte enable have been low for at least one clock. A chip-select low period that runs longer than a configured number of clocks raises a timeout flag.

Top module: `bpsram_rd_responder`

## Requirements
- R1: A burst starts on the first rising edge where `cs_n` and `adv_n` are both low, and `addr` is captured on that edge (edge 0). Later edges of the same `adv_n` low pulse are ignored, so holding `adv_n` low for several clocks does not change the burst timing.
- R2: `wait_oe` equals the inverse of `cs_n`. `wait_o` is low while chip-select is low in idle and after a start edge, until the ready point.
- R3: `wait_o` goes high after edge LAT-1 (edge 4 at the defaults), one clock before the first data word.
- R4: The first word is presented after edge LAT (edge 5 at the defaults).
- R5: Word k of the burst (k = 0..BL-1, delivered after edge LAT+k) is read from address {base[AW-1:2], base[1:0]+k mod 4}. The count wraps inside the aligned group of BL words.
- R6: After the last word, `dq_o` keeps that word and stays driven. Raising `oe_n` removes all lane enables at once.
- R7: Lane i (bit 0 is the lower byte, bit 1 the upper) is driven only while data is valid, `cs_n` is low, `oe_n` and `be_n[i]` are low now, and both were also low at the previous rising edge.
- R8: While `cs_n` is high, `dq_oe`, `wait_oe` and `tmo_err` are all 0. The next edge returns the block to idle, so a new burst can start on the edge after that.
- R9: A new `adv_n` low pulse that arrives while the last word is held starts a fresh burst. `wait_o` is low after its start edge.
- R10: `tmo_err` is high once more than TMO_CYC consecutive rising edges have seen `cs_n` low (125 at 50 MHz and 2500 ns). It clears as soon as `cs_n` goes high.
- R11: When `pl_we` is high at a rising edge, that edge writes `pl_wdata` into array word `pl_addr`.
- R12: While `rst_n` is low, `dq_oe`, `wait_o` and `tmo_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip-select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output-enable, active low |
| be_n | input | 2 | Byte enables, active low, bit 0 lower byte |
| addr | input | 6 | Burst start word address |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 6 | Preload word address |
| pl_wdata | input | 16 | Preload data |
| dq_o | output | 16 | Read data value |
| dq_oe | output | 2 | Per-lane drive enable for dq_o |
| wait_o | output | 1 | Ready indication, high when data is valid or due next clock |
| wait_oe | output | 1 | Drive enable for wait_o |
| tmo_err | output | 1 | Chip-select low period too long |

## Verification
The hold-stability property assumes the preload port stays quiet while a burst is held on the bus. The lane-setup property assumes the host changes `oe_n` and `be_n` only between clock edges. The bench preloads the array before any burst is issued and never writes it afterwards. All strobes are driven on the falling clock edge. Random bursts vary the base address, the length of the address-valid pulse (always shorter than the observation window), the byte-lane pattern and a late output-enable, so every run stays inside these assumptions.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_BURST, ST_HOLD} seq_st_t;

  // Clock count that fits inside a time limit at a given clock rate.
  function automatic int unsigned cycles_for_ns(int unsigned mhz, int unsigned ns);
    return (mhz * ns) / 1000;
  endfunction

  // Word address of beat k in a wrapping burst of length bl (power of two).
  function automatic logic [31:0] burst_addr(logic [31:0] base, logic [31:0] k,
                                             int unsigned bl);
    logic [31:0] m;
    m = bl - 1;
    return (base & ~m) | ((base + k) & m);
  endfunction
endpackage

// File: rtl/bps_store.sv
module bps_store #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pl_we) mem[pl_addr] <= pl_wdata;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/bps_seq.sv
module bps_seq
  import bps_pkg::*;
#(
  parameter int AW  = 6,
  parameter int LAT = 5,
  parameter int BL  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  output logic          start_evt,
  output logic          rdy,
  output logic          data_valid,
  output logic          in_hold,
  output logic [AW-1:0] word_addr
);
  localparam int CNT_W = $clog2(LAT + BL);
  localparam int IDX_W = (BL > 1) ? $clog2(BL) : 1;
  localparam logic [CNT_W-1:0] C_LAT  = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] C_RDY  = CNT_W'(LAT - 1);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(LAT + BL - 1);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [AW-1:0]    base_q;
  logic             adv_used;
  logic [IDX_W-1:0] beat;

  // First edge of an address-valid low pulse, accepted only when free.
  assign start_evt  = ~cs_n & ~adv_n & ~adv_used &
                      ((st == ST_IDLE) || (st == ST_HOLD));
  assign cnt_nxt    = cnt + 1'b1;
  assign data_valid = (st == ST_BURST) || (st == ST_HOLD);
  assign in_hold    = (st == ST_HOLD);
  assign rdy        = data_valid || ((st == ST_LAT) && (cnt >= C_RDY));
  assign beat       = IDX_W'(cnt - C_LAT);
  assign word_addr  = AW'(burst_addr(32'(base_q), 32'(beat), BL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      base_q   <= '0;
      adv_used <= 1'b0;
    end else begin
      adv_used <= ~adv_n & ~cs_n;
      if (cs_n) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else if (start_evt) begin
        st     <= ST_LAT;
        cnt    <= '0;
        base_q <= addr;
      end else begin
        unique case (st)
          ST_LAT: begin
            cnt <= cnt_nxt;
            if (cnt_nxt == C_LAT) st <= (C_LAT == C_LAST) ? ST_HOLD : ST_BURST;
          end
          ST_BURST: begin
            cnt <= cnt_nxt;
            if (cnt_nxt == C_LAST) st <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bps_lanes.sv
module bps_lanes #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  input  logic             data_valid,
  output logic [LANES-1:0] lane_oe
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic setup_q;

    always_ff @(posedge clk) begin
      if (!rst_n) setup_q <= 1'b0;
      else        setup_q <= ~oe_n & ~be_n[g];
    end

    assign lane_oe[g] = data_valid & ~cs_n & ~oe_n & ~be_n[g] & setup_q;
  end
endmodule

// File: rtl/bps_tmo.sv
module bps_tmo #(
  parameter int unsigned LIMIT = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic tmo_err
);
  localparam int TW = $clog2(LIMIT + 2);
  localparam logic [TW-1:0] C_LIM = TW'(LIMIT);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) cnt <= '0;
    else if (cnt <= C_LIM) cnt <= cnt + 1'b1;
  end

  assign tmo_err = ~cs_n & (cnt > C_LIM);
endmodule

// File: rtl/bpsram_rd_responder.sv
module bpsram_rd_responder
  import bps_pkg::*;
#(
  parameter int          DW      = 16,
  parameter int          AW      = 6,
  parameter int          LAT     = 5,
  parameter int          BL      = 4,
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned MAX_NS  = 2500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             adv_n,
  input  logic             oe_n,
  input  logic [DW/8-1:0]  be_n,
  input  logic [AW-1:0]    addr,
  input  logic             pl_we,
  input  logic [AW-1:0]    pl_addr,
  input  logic [DW-1:0]    pl_wdata,
  output logic [DW-1:0]    dq_o,
  output logic [DW/8-1:0]  dq_oe,
  output logic             wait_o,
  output logic             wait_oe,
  output logic             tmo_err
);
  localparam int          LANES   = DW / 8;
  localparam int unsigned TMO_CYC = cycles_for_ns(CLK_MHZ, MAX_NS);

  logic          start_evt;
  logic          rdy;
  logic          data_valid;
  logic          in_hold;
  logic [AW-1:0] word_addr;

  bps_seq #(.AW(AW), .LAT(LAT), .BL(BL)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .adv_n      (adv_n),
    .addr       (addr),
    .start_evt  (start_evt),
    .rdy        (rdy),
    .data_valid (data_valid),
    .in_hold    (in_hold),
    .word_addr  (word_addr)
  );

  bps_store #(.DW(DW), .AW(AW)) u_store (
    .clk      (clk),
    .pl_we    (pl_we),
    .pl_addr  (pl_addr),
    .pl_wdata (pl_wdata),
    .rd_addr  (word_addr),
    .rd_data  (dq_o)
  );

  bps_lanes #(.LANES(LANES)) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .oe_n       (oe_n),
    .be_n       (be_n),
    .data_valid (data_valid),
    .lane_oe    (dq_oe)
  );

  bps_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .tmo_err (tmo_err)
  );

  assign wait_oe = ~cs_n;
  assign wait_o  = rdy & ~cs_n;
endmodule

// File: rtl/bps_chk.sv
module bps_chk #(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             adv_n,
  input logic             oe_n,
  input logic [LANES-1:0] be_n,
  input logic             start_evt,
  input logic             rdy,
  input logic             data_valid,
  input logic             in_hold,
  input logic [DW-1:0]    dq_o,
  input logic [LANES-1:0] dq_oe,
  input logic             wait_oe,
  input logic             tmo_err
);
  // R1: a second edge of one address-valid pulse never restarts the burst
  a_r1_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_n && !cs_n && $past(!adv_n && !cs_n)) |-> !start_evt);

  // R2: a start edge leaves the ready indication low
  a_r2_start_clears_wait: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!rdy || cs_n));

  // R3: ready rises exactly one clock ahead of valid data
  a_r3_wait_leads_data: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    $rose(rdy) |=> (data_valid || cs_n || start_evt));

  // R6: held last word does not move
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    (in_hold && $past(in_hold) && $past(!cs_n)) |-> $stable(dq_o));

  // R8: chip-select high silences every output
  a_r8_cs_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dq_oe == '0 && !wait_oe && !tmo_err));

  // R7: a lane drives only after a clock of enable setup
  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    a_r7_lane_setup: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe[g] |-> ($past(!oe_n && !be_n[g]) && data_valid));
  end
endmodule

bind bpsram_rd_responder bps_chk #(.DW(DW), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .adv_n      (adv_n),
  .oe_n       (oe_n),
  .be_n       (be_n),
  .start_evt  (start_evt),
  .rdy        (rdy),
  .data_valid (data_valid),
  .in_hold    (in_hold),
  .dq_o       (dq_o),
  .dq_oe      (dq_oe),
  .wait_oe    (wait_oe),
  .tmo_err    (tmo_err)
);

// File: tb/tb_bpsram_rd_responder.sv
module tb_bpsram_rd_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  be_n = 2'b11;
  logic [5:0]  addr = '0;
  logic        pl_we = 1'b0;
  logic [5:0]  pl_addr = '0;
  logic [15:0] pl_wdata = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe;
  logic        wait_o, wait_oe, tmo_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [15:0] mdl [64];

  always #10 clk = ~clk;

  bpsram_rd_responder dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
    .be_n(be_n), .addr(addr), .pl_we(pl_we), .pl_addr(pl_addr),
    .pl_wdata(pl_wdata), .dq_o(dq_o), .dq_oe(dq_oe), .wait_o(wait_o),
    .wait_oe(wait_oe), .tmo_err(tmo_err)
  );

  // Beat k of a burst: stay in the aligned group of four, step modulo four.
  function automatic logic [5:0] beat_addr(logic [5:0] b, int k);
    int grp, off;
    grp = (int'(b) / 4) * 4;
    off = (int'(b) % 4 + k) % 4;
    return 6'(grp + off);
  endfunction

  function automatic logic [15:0] lane_mask(logic [1:0] on);
    return {{8{on[1]}}, {8{on[0]}}};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_burst(logic [5:0] base, int adv_hold, logic [1:0] ben, bit late);
    logic [1:0]  exp_on;
    logic [15:0] m;
    int          first;
    first = late ? 6 : 5;
    @(negedge clk);
    cs_n = 1'b0; adv_n = 1'b0; addr = base; be_n = ben; oe_n = late;
    #1;
    chk("R2 wait at cs fall", {30'd0, wait_oe, wait_o}, 32'b10);
    for (int e = 0; e < 12; e++) begin
      @(posedge clk); #5;
      chk(adv_hold > 1 ? "R1 wait timing, adv held" : "R3 wait timing",
          32'(wait_o), 32'(e >= 4));
      exp_on = (e >= first) ? ~ben : 2'b00;
      chk("R7 lane enables", 32'(dq_oe), 32'(exp_on));
      if (e >= 5) begin
        m = lane_mask(~ben);
        chk(e == 5 ? "R4 first word" : (e > 8 ? "R6 held word" : "R5 word order"),
            32'(dq_o & m), 32'(mdl[beat_addr(base, e > 8 ? 3 : e - 5)] & m));
      end
      @(negedge clk);
      if (e + 1 == adv_hold) adv_n = 1'b1;
      if (late && e == 5) oe_n = 1'b0;
    end
    oe_n = 1'b1; #1;
    chk("R6 oe release", 32'(dq_oe), 32'd0);
    cs_n = 1'b1; adv_n = 1'b1; #1;
    chk("R8 cs release", {29'd0, wait_oe, dq_oe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    // R12: outputs quiet in reset even with strobes active
    cs_n = 1'b0; adv_n = 1'b0; oe_n = 1'b0; be_n = 2'b00;
    repeat (3) @(posedge clk);
    #5;
    chk("R12 reset outputs", {30'd0, wait_o, tmo_err}, 32'd0);
    chk("R12 reset lanes", 32'(dq_oe), 32'd0);
    @(negedge clk);
    cs_n = 1'b1; adv_n = 1'b1; oe_n = 1'b1; be_n = 2'b11;
    rst_n = 1'b1;

    // R11: preload the whole array
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      pl_we = 1'b1; pl_addr = 6'(i); pl_wdata = 16'($urandom); mdl[i] = pl_wdata;
    end
    @(negedge clk); pl_we = 1'b0;

    // Directed bursts
    do_burst(6'd0,  1, 2'b00, 1'b0);
    do_burst(6'd6,  5, 2'b00, 1'b0);
    do_burst(6'd31, 8, 2'b00, 1'b1);
    do_burst(6'd13, 2, 2'b10, 1'b0);
    do_burst(6'd42, 1, 2'b01, 1'b0);

    // R8: abort during latency, then a full burst right after
    @(negedge clk);
    cs_n = 1'b0; adv_n = 1'b0; addr = 6'd9; oe_n = 1'b0; be_n = 2'b00;
    repeat (3) @(posedge clk);
    #5 chk("R2 wait low in latency", 32'(wait_o), 32'd0);
    @(negedge clk); cs_n = 1'b1; adv_n = 1'b1; #1;
    chk("R8 abort quiets", {29'd0, wait_oe, dq_oe}, 32'd0);
    do_burst(6'd22, 3, 2'b00, 1'b0);

    // R9: restart while the last word is held
    @(negedge clk);
    cs_n = 1'b0; adv_n = 1'b0; addr = 6'd50; oe_n = 1'b0; be_n = 2'b00;
    @(posedge clk);
    @(negedge clk); adv_n = 1'b1;
    repeat (11) @(posedge clk);
    #5 chk("R6 held before restart", 32'(dq_o), 32'(mdl[beat_addr(6'd50, 3)]));
    @(negedge clk); adv_n = 1'b0; addr = 6'd37;
    @(posedge clk); #5;
    chk("R9 wait low after restart", 32'(wait_o), 32'd0);
    @(negedge clk); adv_n = 1'b1;
    repeat (5) @(posedge clk);
    #5;
    chk("R9 restart lanes", 32'(dq_oe), 32'd3);
    chk("R9 restart first word", 32'(dq_o), 32'(mdl[6'd37]));
    @(negedge clk); cs_n = 1'b1; oe_n = 1'b1;

    // R10: chip-select held low too long
    @(negedge clk); cs_n = 1'b0; adv_n = 1'b1;
    repeat (125) @(posedge clk);
    #5 chk("R10 at limit", 32'(tmo_err), 32'd0);
    @(posedge clk);
    #5 chk("R10 past limit", 32'(tmo_err), 32'd1);
    @(negedge clk); cs_n = 1'b1; #1;
    chk("R10 clear on cs high", 32'(tmo_err), 32'd0);

    // Random bursts
    for (int r = 0; r < 30; r++) begin
      do_burst(6'($urandom), 1 + int'($urandom % 7), 2'($urandom),
               ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule